// File: doc/BRIEF.md
# External Request Flow Gate

This block decides, cycle by cycle, whether a DMA channel may move data. It watches two asynchronous, active-low pins (a data-request pin and a start pin) together with a few mode fields, and drives a single run-permit output to the datapath. In return, the datapath pulses a strobe once for every byte it moves while the permit is high.

A rising edge on the software go bit starts the channel. If the external-start mode is set, that edge only arms the channel, and the transfer begins once the start pin is seen low. In external-pause mode the channel may move a quota of 2^code bytes. It then parks in a paused state and stays there until the request pin shows a new high-to-low transition. A halt pulse returns the block to idle from any state. After a halt, the pins cannot restart the channel: only a fresh go edge can.

Top module: `xrq_flow_gate`

## Requirements
- R1: After reset, run_ok and paused are both 0.
- R2: With external start disabled, a rising edge of cfg_go sets run_ok on the next clock edge.
- R3: With external start enabled, a go edge only arms the channel. run_ok stays 0 until xstart_n is low, and rises on the third clock edge after xstart_n falls.
- R4: With external pause on and quota code k in 1..10, run_ok stays 1 for 2^k byte strobes. The clock edge that takes the 2^k-th strobe sets paused=1 and run_ok=0.
- R5: Quota codes 11 to 15 give the largest quota of 1024 bytes.
- R6: Quota code 0, or cfg_xpause_en=0, disables pausing. The channel never pauses, and dreq_n has no effect.
- R7: A paused channel resumes (run_ok=1, paused=0) with a fresh quota on the third clock edge after a high-to-low transition of dreq_n. A level held low does not resume it a second time.
- R8: A falling edge of dreq_n while the channel is not paused is dropped, not stored. The next pause still needs a new edge.
- R9: halt forces run_ok=0 and paused=0 on the next edge. An armed state is cleared too, so xstart_n cannot start the channel until a new go edge.
- R10: Byte strobes taken while run_ok is 0 (armed or paused) do not use up the quota.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_go | input | 1 | Software go bit; its rising edge starts or arms the channel |
| cfg_xstart_en | input | 1 | Wait for the start pin after a go edge |
| cfg_xpause_en | input | 1 | Enable pausing after each byte quota |
| cfg_quota_code | input | 4 | log2 of the byte quota; 0 disables pausing |
| halt | input | 1 | Pulse that stops the channel and clears arming |
| dreq_n | input | 1 | Asynchronous active-low request pin |
| xstart_n | input | 1 | Asynchronous active-low start pin |
| byte_stb | input | 1 | One pulse per byte moved by the datapath |
| run_ok | output | 1 | Permit for the datapath to move data |
| paused | output | 1 | Channel is waiting for a new request edge |

## Verification
A byte counter that is off by one shows up at the ports as a pause one strobe early or late, so the exact strobe on which run_ok drops is checked for every quota used. A request edge that the design kept when it should have dropped it appears as a paused channel resuming with no new edge. A synchronizer or edge detector with the wrong depth moves the resume or start by a whole cycle. These faults show up within three clocks of the pin change, and the checks sample both sides of that window.

// File: rtl/xrq_pkg.sv
package xrq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } xrq_state_e;
endpackage

// File: rtl/xrq_sync.sv
module xrq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level_n,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_n = chain_q[STAGES-1];
  assign fall    = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/xrq_quota.sv
module xrq_quota #(
  parameter int MAX_LOG2 = 10,
  parameter int CODE_W   = 4,
  localparam int CNT_W   = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              load,
  input  logic              dec,
  output logic              last
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] quota;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (int'(code) > MAX_LOG2) quota = ONE << MAX_LOG2;
    else                       quota = ONE << code;
  end

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)                   cnt_d = quota;
    else if (dec && cnt_q != 0) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/xrq_flow_gate.sv
module xrq_flow_gate #(
  parameter int MAX_LOG2    = 10,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_go,
  input  logic              cfg_xstart_en,
  input  logic              cfg_xpause_en,
  input  logic [CODE_W-1:0] cfg_quota_code,
  input  logic              halt,
  input  logic              dreq_n,
  input  logic              xstart_n,
  input  logic              byte_stb,
  output logic              run_ok,
  output logic              paused
);
  import xrq_pkg::*;

  xrq_state_e st_q, st_d;
  logic       go_q;
  logic       go_rise;
  logic       pause_on;
  logic       req_fall;
  logic       req_level_n;
  logic       strt_level_n;
  logic       strt_fall;
  logic       cnt_load;
  logic       cnt_dec;
  logic       cnt_last;

  xrq_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (dreq_n),
    .level_n (req_level_n),
    .fall    (req_fall)
  );

  xrq_sync #(.STAGES(SYNC_STAGES)) u_strt_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (xstart_n),
    .level_n (strt_level_n),
    .fall    (strt_fall)
  );

  xrq_quota #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W)) u_quota (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (cfg_quota_code),
    .load  (cnt_load),
    .dec   (cnt_dec),
    .last  (cnt_last)
  );

  assign go_rise  = cfg_go & ~go_q;
  assign pause_on = cfg_xpause_en & (cfg_quota_code != '0);
  assign cnt_dec  = byte_stb & (st_q == ST_RUN);

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    if (halt) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go_rise) begin
            if (cfg_xstart_en) begin
              st_d = ST_ARMED;
            end else begin
              st_d     = ST_RUN;
              cnt_load = 1'b1;
            end
          end
        end
        ST_ARMED: begin
          if (!strt_level_n) begin
            st_d     = ST_RUN;
            cnt_load = 1'b1;
          end
        end
        ST_RUN: begin
          if (pause_on && byte_stb && cnt_last) st_d = ST_HOLD;
        end
        ST_HOLD: begin
          if (req_fall) begin
            st_d     = ST_RUN;
            cnt_load = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      go_q <= 1'b0;
    end else begin
      st_q <= st_d;
      go_q <= cfg_go;
    end
  end

  assign run_ok = (st_q == ST_RUN);
  assign paused = (st_q == ST_HOLD);
endmodule

// File: rtl/xrq_flow_gate_chk.sv
module xrq_flow_gate_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_xpause_en,
  input logic [CODE_W-1:0] cfg_quota_code,
  input logic              halt,
  input logic              byte_stb,
  input logic              run_ok,
  input logic              paused
);
  // R4
  hold_excludes_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(paused && run_ok));

  // R4
  pause_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(byte_stb));

  // R10
  run_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_ok) |-> $past(byte_stb || halt));

  // R9
  halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run_ok && !paused));

  // R6
  no_pause_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !halt && !(cfg_xpause_en && cfg_quota_code != '0)) |=> run_ok);

  // R7
  resume_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(paused) && !$past(halt)) |-> run_ok);
endmodule

bind xrq_flow_gate xrq_flow_gate_chk #(.CODE_W(CODE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_xpause_en  (cfg_xpause_en),
  .cfg_quota_code (cfg_quota_code),
  .halt           (halt),
  .byte_stb       (byte_stb),
  .run_ok         (run_ok),
  .paused         (paused)
);

// File: tb/sim_xrq_flow_gate.sv
module sim_xrq_flow_gate;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_go, cfg_xstart_en, cfg_xpause_en;
  logic [3:0] cfg_quota_code;
  logic       halt, dreq_n, xstart_n, byte_stb;
  logic       run_ok, paused;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xrq_flow_gate u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_go         (cfg_go),
    .cfg_xstart_en  (cfg_xstart_en),
    .cfg_xpause_en  (cfg_xpause_en),
    .cfg_quota_code (cfg_quota_code),
    .halt           (halt),
    .dreq_n         (dreq_n),
    .xstart_n       (xstart_n),
    .byte_stb       (byte_stb),
    .run_ok         (run_ok),
    .paused         (paused)
  );

  function automatic int quota_of(input int code);
    if (code > 10) return 1024;
    return 1 << code;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic er, input logic ep);
    chk({req, " run_ok"}, run_ok, er);
    chk({req, " paused"}, paused, ep);
  endtask

  task automatic launch();
    @(negedge clk) cfg_go = 1'b1;
    @(negedge clk) cfg_go = 1'b0;
  endtask

  task automatic do_halt();
    @(negedge clk) halt = 1'b1;
    @(negedge clk) halt = 1'b0;
  endtask

  task automatic strobes(input int n, input int max_gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) byte_stb = 1'b1;
      @(negedge clk) byte_stb = 1'b0;
      if (max_gap > 0) repeat ($urandom_range(max_gap, 0)) @(negedge clk);
    end
  endtask

  task automatic req_pulse();
    @(negedge clk) dreq_n = 1'b0;
    repeat (4) @(negedge clk);
    dreq_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hung expected finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_go = 1'b0; cfg_xstart_en = 1'b0; cfg_xpause_en = 1'b0;
    cfg_quota_code = 4'd0; halt = 1'b0; dreq_n = 1'b1; xstart_n = 1'b1; byte_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk_state("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_state("R1 after release", 1'b0, 1'b0);

    // R2 / R6: immediate start, pausing disabled
    launch();
    chk_state("R2 go starts", 1'b1, 1'b0);
    strobes(50, 1);
    req_pulse();
    chk_state("R6 pause off never pauses", 1'b1, 1'b0);
    do_halt();
    chk_state("R9 halt stops", 1'b0, 1'b0);

    // R6: pause enabled but code 0
    cfg_xpause_en = 1'b1; cfg_quota_code = 4'd0;
    launch();
    strobes(40, 0);
    chk_state("R6 code zero never pauses", 1'b1, 1'b0);
    do_halt();

    // R3 / R10: external start
    cfg_xstart_en = 1'b1; cfg_quota_code = 4'd3;
    launch();
    strobes(5, 0);
    repeat (4) @(negedge clk);
    chk_state("R3 armed waits", 1'b0, 1'b0);
    xstart_n = 1'b0;
    @(negedge clk);
    chk_state("R3 not before sync", 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk_state("R3 start pin starts", 1'b1, 1'b0);
    xstart_n = 1'b1;
    strobes(7, 0);
    chk_state("R10 armed strobes not counted", 1'b1, 1'b0);
    strobes(1, 0);
    chk_state("R4 quota 8 reached", 1'b0, 1'b1);
    strobes(3, 0);
    chk_state("R10 paused strobes ignored", 1'b0, 1'b1);

    // R7: resume on edge, held level does not resume again
    @(negedge clk) dreq_n = 1'b0;
    @(negedge clk);
    chk_state("R7 not before sync", 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk_state("R7 edge resumes", 1'b1, 1'b0);
    strobes(8, 0);
    repeat (6) @(negedge clk);
    chk_state("R7 held low stays paused", 1'b0, 1'b1);
    dreq_n = 1'b1;
    repeat (3) @(negedge clk);
    req_pulse();
    chk_state("R7 new edge resumes", 1'b1, 1'b0);

    // R8: edge while running is dropped
    req_pulse();
    strobes(8, 0);
    repeat (6) @(negedge clk);
    chk_state("R8 running edge not queued", 1'b0, 1'b1);

    // R9: halt clears arming
    do_halt();
    chk_state("R9 halt from pause", 1'b0, 1'b0);
    @(negedge clk) xstart_n = 1'b0;
    repeat (6) @(negedge clk);
    chk_state("R9 pin cannot restart", 1'b0, 1'b0);
    xstart_n = 1'b1;
    cfg_xstart_en = 1'b0;
    repeat (3) @(negedge clk);

    // R5: large code clamps to 1024
    cfg_quota_code = 4'd13;
    launch();
    strobes(1023, 0);
    chk_state("R5 before 1024", 1'b1, 1'b0);
    strobes(1, 0);
    chk_state("R5 at 1024", 1'b0, 1'b1);
    do_halt();

    // R4 / R7: random quotas with random strobe gaps
    for (int it = 0; it < 12; it++) begin
      int code;
      int q;
      code = $urandom_range(7, 1);
      q = quota_of(code);
      cfg_quota_code = 4'(code);
      launch();
      strobes(q - 1, 2);
      chk_state("R4 random before quota", 1'b1, 1'b0);
      strobes(1, 0);
      chk_state("R4 random at quota", 1'b0, 1'b1);
      req_pulse();
      chk_state("R7 random resume", 1'b1, 1'b0);
      strobes(q, 0);
      chk_state("R4 random second quota", 1'b0, 1'b1);
      do_halt();
    end

    finish_run();
  end
endmodule